// File: doc/BRIEF.md
# Transmit Jabber Watchdog

This block guards the transmit path of an Ethernet MAC against a station that never stops sending. It counts how long the transmit-enable input from the MAC stays asserted. When that time passes a configured limit, it latches a jabber state. In that state it raises a status flag and drives two gating outputs that shut off transmission and internal loopback.

The jabber state is left only after transmit-enable has stayed low, without a break, for a full unjab window. All timing comes from a single-cycle millisecond strobe. Both limits are tick-count parameters, so a simulation can use very short windows. The transmit limit is meant to be set between 20 and 150 ticks, and the unjab window between 250 and 750 ticks.

An active-low strap switches the whole function off. The jabber flag is also wired out to the link-pulse status encoder, which uses it to report local jabber to the far end.

Top module: `jabber_wdog`

## Requirements
- R1: While rst_ni is low (asynchronous), jabber_o, tx_gate_o and lpbk_gate_o are low and both internal tick counts are zero.
- R2: With jab_en_ni high, jabber_o rises on the clock edge that samples the TX_LIMIT_TICKS-th ms_tick_i pulse seen while tx_en_i has stayed high; with fewer such pulses it stays low.
- R3: A single cycle with tx_en_i low, before the limit is reached, restarts the transmit tick count from zero.
- R4: tx_gate_o and lpbk_gate_o are high in exactly the cycles in which jabber_o is high.
- R5: Once set, jabber_o stays high for as long as tx_en_i is high, however many ticks arrive.
- R6: In jabber, jabber_o falls on the edge that samples the UNJAB_TICKS-th ms_tick_i pulse seen while tx_en_i has stayed low; any cycle with tx_en_i high restarts that count from zero.
- R7: When jab_en_ni is low, jabber_o goes low at the next edge (even from jabber), both counts clear and ticks are not counted; after the strap is released, timing starts from zero.
- R8: Cycles without an ms_tick_i pulse do not advance either count, so holding tx_en_i high without ticks never causes jabber.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| jab_en_ni | input | 1 | Watchdog enable strap; low disables the function |
| ms_tick_i | input | 1 | One-cycle 1 ms timebase strobe |
| jabber_o | output | 1 | Jabber state flag, also fed to link status signaling |
| tx_gate_o | output | 1 | High to inhibit transmission |
| lpbk_gate_o | output | 1 | High to inhibit internal loopback |

## Verification
The directed patterns cover several cases. One holds transmit-enable high with no ticks, which shows that only strobes count (R8). One runs to one tick short of the limit and then to the limit, which places the trip edge exactly. A one-cycle gap before the limit proves the transmit count restarts (R3). A one-cycle reassertion inside the unjab window proves that count restarts as well (R6). Pulling the strap low during jabber, and during a long transmission, separates a disabled watchdog from one that is merely not counting. Random runs of transmit bursts with sparse random ticks and an occasional strap drop are then compared cycle by cycle against a bench model of the requirements.

// File: rtl/jabber_pkg.sv
package jabber_pkg;
  typedef struct packed {
    logic clr;
    logic adv;
  } cnt_ctl_t;

  typedef enum logic {
    ST_WATCH = 1'b0,
    ST_JAB   = 1'b1
  } jab_state_e;
endpackage

// File: rtl/jab_tick_cnt.sv
module jab_tick_cnt
  import jabber_pkg::*;
#(
  parameter int unsigned LIMIT = 50
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  cnt_ctl_t ctl_i,
  output logic     hit_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign hit_o = ctl_i.adv && !ctl_i.clr && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (ctl_i.clr || hit_o) cnt_q <= '0;
    else if (ctl_i.adv)         cnt_q <= cnt_q + 1'b1;
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < W'(LIMIT));

  // R3
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_i.clr |=> cnt_q == '0);

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_i.adv && !ctl_i.clr) |=> $stable(cnt_q));
endmodule

// File: rtl/jab_fsm.sv
module jab_fsm
  import jabber_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tx_en_i,
  input  logic     en_ni,
  input  logic     tick_i,
  input  logic     tx_hit_i,
  input  logic     unjab_hit_i,
  output cnt_ctl_t tx_ctl_o,
  output cnt_ctl_t unjab_ctl_o,
  output logic     jab_o
);
  jab_state_e state_q, state_d;
  logic       active;

  assign active = en_ni;
  assign jab_o  = (state_q == ST_JAB);

  always_comb begin
    tx_ctl_o.clr    = !active || jab_o || !tx_en_i;
    tx_ctl_o.adv    = active && !jab_o && tx_en_i && tick_i;
    unjab_ctl_o.clr = !active || !jab_o || tx_en_i;
    unjab_ctl_o.adv = active && jab_o && !tx_en_i && tick_i;
  end

  always_comb begin
    state_d = state_q;
    if (!active)                           state_d = ST_WATCH;
    else if (state_q == ST_WATCH && tx_hit_i) state_d = ST_JAB;
    else if (state_q == ST_JAB && unjab_hit_i) state_d = ST_WATCH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_WATCH;
    else         state_q <= state_d;
  end

  // R2
  jab_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(jab_o) |-> $past(tx_en_i && tick_i && en_ni));

  // R6
  jab_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(jab_o) |-> $past((!tx_en_i && tick_i) || !en_ni));

  // R5
  jab_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jab_o && tx_en_i && en_ni) |=> jab_o);
endmodule

// File: rtl/jabber_wdog.sv
module jabber_wdog
  import jabber_pkg::*;
#(
  parameter int unsigned TX_LIMIT_TICKS = 50,
  parameter int unsigned UNJAB_TICKS    = 500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  input  logic jab_en_ni,
  input  logic ms_tick_i,
  output logic jabber_o,
  output logic tx_gate_o,
  output logic lpbk_gate_o
);
  cnt_ctl_t tx_ctl, unjab_ctl;
  logic     tx_hit, unjab_hit, jab;

  jab_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tx_en_i     (tx_en_i),
    .en_ni       (jab_en_ni),
    .tick_i      (ms_tick_i),
    .tx_hit_i    (tx_hit),
    .unjab_hit_i (unjab_hit),
    .tx_ctl_o    (tx_ctl),
    .unjab_ctl_o (unjab_ctl),
    .jab_o       (jab)
  );

  jab_tick_cnt #(.LIMIT(TX_LIMIT_TICKS)) u_tx_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (tx_ctl),
    .hit_o  (tx_hit)
  );

  jab_tick_cnt #(.LIMIT(UNJAB_TICKS)) u_unjab_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ctl_i  (unjab_ctl),
    .hit_o  (unjab_hit)
  );

  assign jabber_o    = jab;
  assign tx_gate_o   = jab;
  assign lpbk_gate_o = jab;

  // R7
  strap_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jab_en_ni |=> !jabber_o);

  // R8
  no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ms_tick_i |=> $stable(jabber_o) || !jabber_o);
endmodule

// File: tb/sim_jabber_wdog.sv
module sim_jabber_wdog;
  localparam int TXL = 5;
  localparam int UNJ = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_en = 1'b0, en_n = 1'b1, tick = 1'b0;
  logic jab, txg, lbg;

  int total = 0, bad = 0, cycles = 0;
  int m_jab = 0, m_tc = 0, m_uc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  jabber_wdog #(.TX_LIMIT_TICKS(TXL), .UNJAB_TICKS(UNJ)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tx_en_i(tx_en), .jab_en_ni(en_n),
    .ms_tick_i(tick), .jabber_o(jab), .tx_gate_o(txg), .lpbk_gate_o(lbg)
  );

  function automatic void model_step(logic t, logic k, logic s);
    if (!s) begin m_jab = 0; m_tc = 0; m_uc = 0; end
    else if (m_jab == 0) begin
      if (!t) m_tc = 0;
      else if (k) begin
        if (m_tc + 1 >= TXL) begin m_jab = 1; m_tc = 0; m_uc = 0; end
        else m_tc++;
      end
    end else begin
      if (t) m_uc = 0;
      else if (k) begin
        if (m_uc + 1 >= UNJ) begin m_jab = 0; m_uc = 0; m_tc = 0; end
        else m_uc++;
      end
    end
  endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(string req, logic t, logic k, logic s);
    @(negedge clk);
    tx_en = t; tick = k; en_n = s;
    @(posedge clk);
    model_step(t, k, s);
    #1;
    chk(req, jab, m_jab[0]);
    chk("R4", txg, m_jab[0]);
    chk("R4", lbg, m_jab[0]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; tx_en = 1'b0; tick = 1'b0; en_n = 1'b1;
    #1;
    m_jab = 0; m_tc = 0; m_uc = 0;
    chk("R1", jab, 1'b0);
    chk("R1", txg, 1'b0);
    chk("R1", lbg, 1'b0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // drive n ticks with gaps
  task automatic ticks(string req, int n, logic t);
    for (int i = 0; i < n; i++) begin
      cyc(req, t, 1'b0, 1'b1);
      cyc(req, t, 1'b1, 1'b1);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R8: long transmit without ticks
    for (int i = 0; i < 30; i++) cyc("R8", 1'b1, 1'b0, 1'b1);
    // R2: one short of limit, then limit
    ticks("R2", TXL - 1, 1'b1);
    chk("R2", jab, 1'b0);
    ticks("R2", 1, 1'b1);
    chk("R2", jab, 1'b1);
    // R5: stays in jabber while transmitting
    ticks("R5", 3 * UNJ, 1'b1);
    // R6: idle almost full window, reassert once, restart
    ticks("R6", UNJ - 1, 1'b0);
    cyc("R6", 1'b1, 1'b0, 1'b1);
    ticks("R6", UNJ - 1, 1'b0);
    chk("R6", jab, 1'b1);
    ticks("R6", 1, 1'b0);
    chk("R6", jab, 1'b0);
    // R3: gap restarts transmit count
    ticks("R3", TXL - 1, 1'b1);
    cyc("R3", 1'b0, 1'b0, 1'b1);
    ticks("R3", TXL - 1, 1'b1);
    chk("R3", jab, 1'b0);
    ticks("R3", 1, 1'b1);
    chk("R3", jab, 1'b1);
    // R7: strap low clears jabber and blocks counting
    cyc("R7", 1'b1, 1'b0, 1'b0);
    chk("R7", jab, 1'b0);
    for (int i = 0; i < 3 * TXL; i++) cyc("R7", 1'b1, 1'b1, 1'b0);
    ticks("R7", TXL - 1, 1'b1);
    chk("R7", jab, 1'b0);
    ticks("R7", 1, 1'b1);
    // R1: reset during jabber
    do_reset();
    // random mix
    for (int i = 0; i < 6000; i++) begin
      logic t, k, s;
      t = ($urandom % 100) < ((tx_en) ? 95 : 20);
      k = ($urandom % 3) == 0;
      s = ($urandom % 200) != 0;
      cyc("R2", t, k, s);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule